// File: doc/BRIEF.md
# Fixed-Latency Link Receive Elastic Buffer

This block sits behind the decoder of an asynchronous serial receiver. Each cycle of the recovered link clock it gets one 16-bit word and a tag that says whether the word is payload or a filler. The link clock runs faster than the system clock, and the sender pads the stream with fillers so that the average payload rate matches the system clock. The block discards the fillers and checks a CRC over each group of four payload words on the link side. It stores the payload in a 16-entry dual-clock buffer built from ordinary registers. Gray-coded pointers cross between the two clock domains.

On the system side, release of data waits until the synchronised fill level reaches a depth set on an input. After that point the block makes one read attempt in every system cycle. The time from a word's arrival to its release therefore stays constant while the stream is healthy. Three status outputs report problems in the system clock domain:

- A one-cycle CRC error pulse, carried across by a toggle.
- A sticky underflow flag.
- A sticky overflow flag.

Top module: `link_rx_elastic`

## Requirements
- R1: Only words presented with `lnk_is_data` high are stored, and `lnk_is_data` low leaves the write pointer unchanged. Stored words leave on `out_word` in arrival order, and no filler ever appears there.
- R2: Payload words are counted from reset in groups of four. Over words 0, 1 and 2 of each group, taken MSB first and 16 bits each, the block computes a CRC with polynomial 0x1021, seed 0xFFFF and no reflection. If word 3 differs from that CRC, `crc_error` goes high for exactly one system cycle. A group whose check word matches causes no pulse.
- R3: After reset, `out_valid` stays low and `out_word` stays zero until the synchronised fill level is at least `start_depth`. The first valid word therefore appears only after at least `start_depth` payload words have been accepted.
- R4: Once release has started, the block makes one read attempt in every system cycle. When payload arrives at exactly the system rate, `out_valid` stays high in every cycle with no gap, and `underflow` stays low.
- R5: A read attempt on an empty buffer sets `out_word` to zero and `out_valid` low. It also sets `underflow`, which stays high until reset.
- R6: A payload word that arrives while all 16 entries are occupied is dropped. The fill level never exceeds 16, and `overflow` rises in the system domain and stays high until reset.
- R7: Each pointer crosses domains as a Gray code through a two-stage synchroniser and changes by at most one bit per cycle of its own clock.
- R8: While reset is held, `out_word`, `out_valid`, `crc_error`, `underflow` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lnk_clk | input | 1 | Recovered link clock |
| lnk_rst_n | input | 1 | Active-low asynchronous reset, link domain |
| lnk_word | input | 16 | Decoded word from the link |
| lnk_is_data | input | 1 | 1 = payload word, 0 = filler |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| start_depth | input | 5 | Fill level at which release begins |
| out_word | output | 16 | Released word, zero when not valid |
| out_valid | output | 1 | `out_word` carries a payload word this cycle |
| crc_error | output | 1 | One-cycle pulse for each group whose CRC fails |
| underflow | output | 1 | Sticky: a read attempt found the buffer empty |
| overflow | output | 1 | Sticky: a payload word was dropped because the buffer was full |

## Verification
The bench sweeps several start depths with a stream that has one filler in every five link cycles. At that ratio the payload rate equals the system rate exactly, so a filler leaking into storage shows up as a sequence mismatch. A pointer or synchroniser fault shows up as a reordered or stale word, or as a gap in the output. A run with no fillers forces the buffer full, and a design that wrapped instead of dropping would never raise `overflow` and would deliver every word. Single-bit corruption of selected check words must give exactly one pulse per bad group. A toggle crossing that was missing or doubled would lose pulses or emit extra ones. When every stream ends, the buffer drains to empty, and a design that let stale data through or kept `out_valid` high would fail the zero-word and sticky-underflow checks.

// File: rtl/link_rx_elastic_pkg.sv
package link_rx_elastic_pkg;

  localparam int unsigned WORD_W = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef logic [WORD_W-1:0] word_t;

  // Advance a CRC-16 register over one word, most significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input word_t w);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[15] ^ w[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '{default: '0};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rxeb_gray2bin.sv
module rxeb_gray2bin #(
  parameter int W = 5
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end

endmodule

// File: rtl/rxeb_crc_chk.sv
module rxeb_crc_chk
  import link_rx_elastic_pkg::*;
#(
  parameter int FRAME_WORDS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t word,
  input  logic  is_data,
  output logic  err_tgl
);

  localparam int PW = $clog2(FRAME_WORDS);

  logic [PW-1:0] pos;
  logic [15:0]   acc;
  logic          at_check;
  logic          frame_bad;
  logic [15:0]   acc_base;

  assign at_check  = (pos == PW'(FRAME_WORDS - 1));
  assign acc_base  = (pos == '0) ? CRC_SEED : acc;
  assign frame_bad = is_data && at_check && (word != acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      acc     <= CRC_SEED;
      err_tgl <= 1'b0;
    end else if (is_data) begin
      if (at_check) begin
        pos <= '0;
      end else begin
        pos <= pos + PW'(1);
        acc <= crc16_step(acc_base, word);
      end
      if (frame_bad) err_tgl <= ~err_tgl;
    end
  end

endmodule

// File: rtl/link_rx_elastic.sv
module link_rx_elastic
  import link_rx_elastic_pkg::*;
#(
  parameter int AW          = 4,
  parameter int FRAME_WORDS = 4
) (
  input  logic        lnk_clk,
  input  logic        lnk_rst_n,
  input  word_t       lnk_word,
  input  logic        lnk_is_data,
  input  logic        sys_clk,
  input  logic        sys_rst_n,
  input  logic [AW:0] start_depth,
  output word_t       out_word,
  output logic        out_valid,
  output logic        crc_error,
  output logic        underflow,
  output logic        overflow
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);

  // link-domain state
  logic [PW-1:0] wr_bin, wr_gray, wr_bin_nx;
  logic [PW-1:0] rd_gray_l, rd_bin_l, occ_lnk;
  logic          buf_full, wr_en, ovf_lnk, crc_tgl;
  word_t         mem [DEPTH];

  // system-domain state
  logic [PW-1:0] rd_bin, rd_gray, rd_bin_nx;
  logic [PW-1:0] wr_gray_s, wr_bin_s, occ_sys;
  logic          buf_empty, start_hit, started_q;
  logic          pop_ok, pop_miss;
  logic          tgl_s, tgl_d;

  // ---------------- link clock domain ----------------
  rxeb_sync #(.W(PW), .STAGES(2)) u_rd_to_lnk (
    .clk(lnk_clk), .rst_n(lnk_rst_n), .d(rd_gray), .q(rd_gray_l)
  );

  rxeb_gray2bin #(.W(PW)) u_rd_dec (.g(rd_gray_l), .b(rd_bin_l));

  assign occ_lnk   = wr_bin - rd_bin_l;
  assign buf_full  = (occ_lnk == FULL_OCC);
  assign wr_en     = lnk_is_data && !buf_full;
  assign wr_bin_nx = wr_bin + PW'(1);

  always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
    if (!lnk_rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      ovf_lnk <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_bin  <= wr_bin_nx;
        wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
      end
      if (lnk_is_data && buf_full) ovf_lnk <= 1'b1;
    end
  end

  always_ff @(posedge lnk_clk) begin
    if (wr_en) mem[wr_bin[AW-1:0]] <= lnk_word;
  end

  rxeb_crc_chk #(.FRAME_WORDS(FRAME_WORDS)) u_crc (
    .clk(lnk_clk), .rst_n(lnk_rst_n), .word(lnk_word),
    .is_data(lnk_is_data), .err_tgl(crc_tgl)
  );

  // ---------------- system clock domain ----------------
  rxeb_sync #(.W(PW), .STAGES(2)) u_wr_to_sys (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  rxeb_gray2bin #(.W(PW)) u_wr_dec (.g(wr_gray_s), .b(wr_bin_s));

  assign occ_sys   = wr_bin_s - rd_bin;
  assign buf_empty = (occ_sys == '0);
  assign start_hit = (occ_sys >= start_depth);
  assign pop_ok    = started_q && !buf_empty;
  assign pop_miss  = started_q && buf_empty;
  assign rd_bin_nx = rd_bin + PW'(1);

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rd_bin    <= '0;
      rd_gray   <= '0;
      started_q <= 1'b0;
      out_word  <= '0;
      out_valid <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (!started_q && start_hit) started_q <= 1'b1;
      if (pop_ok) begin
        out_word  <= mem[rd_bin[AW-1:0]];
        out_valid <= 1'b1;
        rd_bin    <= rd_bin_nx;
        rd_gray   <= rd_bin_nx ^ (rd_bin_nx >> 1);
      end else begin
        out_word  <= '0;
        out_valid <= 1'b0;
      end
      if (pop_miss) underflow <= 1'b1;
    end
  end

  rxeb_sync #(.W(1), .STAGES(2)) u_crc_to_sys (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(crc_tgl), .q(tgl_s)
  );

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      tgl_d     <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      tgl_d     <= tgl_s;
      crc_error <= tgl_s ^ tgl_d;
    end
  end

  rxeb_sync #(.W(1), .STAGES(2)) u_ovf_to_sys (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(ovf_lnk), .q(overflow)
  );

endmodule

module link_rx_elastic_chk #(
  parameter int PW    = 5,
  parameter int DEPTH = 16
) (
  input logic          sys_clk,
  input logic          sys_rst_n,
  input logic          lnk_clk,
  input logic          lnk_rst_n,
  input logic          lnk_is_data,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray,
  input logic [PW-1:0] occ_lnk,
  input logic          started_q,
  input logic          out_valid,
  input logic [15:0]   out_word,
  input logic          underflow,
  input logic          overflow,
  input logic          crc_error
);

  p_filler_skip_r1: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    !lnk_is_data |=> $stable(wr_gray));

  p_crc_pulse_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    crc_error |=> !crc_error);

  p_start_gate_r3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !started_q |=> !out_valid);

  p_one_per_cycle_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    started_q |=> (out_valid || underflow));

  p_zero_word_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !out_valid |-> (out_word == '0));

  p_underflow_sticky_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    underflow |=> underflow);

  p_no_overflow_r6: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    occ_lnk <= PW'(DEPTH));

  p_overflow_sticky_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    overflow |=> overflow);

  p_wr_gray_step_r7: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_rd_gray_step_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

bind link_rx_elastic link_rx_elastic_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
  .lnk_clk(lnk_clk), .lnk_rst_n(lnk_rst_n),
  .lnk_is_data(lnk_is_data),
  .wr_gray(wr_gray), .rd_gray(rd_gray), .occ_lnk(occ_lnk),
  .started_q(started_q), .out_valid(out_valid), .out_word(out_word),
  .underflow(underflow), .overflow(overflow), .crc_error(crc_error)
);

// File: tb/link_rx_elastic_test.sv
module link_rx_elastic_test;
  import link_rx_elastic_pkg::*;

  localparam int AW = 4;
  localparam int PW = AW + 1;

  logic        lnk_clk = 1'b0;
  logic        sys_clk = 1'b0;
  logic        lnk_rst_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  word_t       lnk_word = '0;
  logic        lnk_is_data = 1'b0;
  logic [AW:0] start_depth = '0;
  word_t       out_word;
  logic        out_valid, crc_error, underflow, overflow;

  link_rx_elastic #(.AW(AW), .FRAME_WORDS(4)) uut (
    .lnk_clk(lnk_clk), .lnk_rst_n(lnk_rst_n), .lnk_word(lnk_word),
    .lnk_is_data(lnk_is_data), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .start_depth(start_depth), .out_word(out_word), .out_valid(out_valid),
    .crc_error(crc_error), .underflow(underflow), .overflow(overflow)
  );

  // link 62.5 MHz, system 50 MHz; the edges of the two clocks never coincide
  initial forever #8 lnk_clk = ~lnk_clk;
  initial begin
    #3;
    forever #10 sys_clk = ~sys_clk;
  end

  int    n_chk = 0;
  int    n_bad = 0;
  word_t exp_w [0:127];
  int    exp_n, tx_cnt, rx_cnt, crc_cnt, first_tx, gaps;
  bit    mon_en = 1'b0;
  bit    seen_first, ordered_mode;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // bit-serial CRC over a whole three-word message
  function automatic logic [15:0] ref_crc(input logic [47:0] m);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 47; i >= 0; i--) begin
      if (r[15] ^ m[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  always @(negedge sys_clk) begin
    if (mon_en) begin
      if (crc_error) crc_cnt++;
      if (out_valid) begin
        if (!seen_first) begin
          seen_first = 1'b1;
          first_tx   = tx_cnt;
        end
        if (ordered_mode) begin
          // R1 order and R7 integrity across the Gray-pointer crossing
          if (rx_cnt < exp_n) check(out_word == exp_w[rx_cnt], "R1 word order", out_word, exp_w[rx_cnt]);
          else                check(1'b0, "R1 extra word", rx_cnt, exp_n);
        end
        rx_cnt++;
        if (ordered_mode && rx_cnt == exp_n)
          check(underflow == 1'b0, "R4 underflow during stream", underflow, 0);
      end else if (seen_first && rx_cnt < exp_n) begin
        gaps++;
      end
    end
  end

  task automatic run_sweep(input int sweep, input int depth, input int nframes,
                           input bit fillers, input bit ordered);
    int    bad_exp;
    int    idx;
    int    cyc;
    word_t w0, w1, w2, cw;
    mon_en      = 1'b0;
    lnk_is_data = 1'b0;
    lnk_word    = '0;
    lnk_rst_n   = 1'b0;
    sys_rst_n   = 1'b0;
    start_depth = PW'(depth);
    repeat (4) @(negedge sys_clk);
    check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    check(out_word  == '0,   "R8 reset out_word", out_word, 0);
    check(crc_error == 1'b0, "R8 reset crc_error", crc_error, 0);
    check(underflow == 1'b0, "R8 reset underflow", underflow, 0);
    check(overflow  == 1'b0, "R8 reset overflow", overflow, 0);

    bad_exp = 0;
    exp_n   = 0;
    for (int f = 0; f < nframes; f++) begin
      w0 = 16'(sweep * 4096 + f * 37 + 5);
      w1 = w0 ^ 16'hA5A5;
      w2 = 16'(w0 * 3 + 16'd1);
      cw = ref_crc({w0, w1, w2});
      if (sweep > 0 && (f % 5) == (sweep % 5)) begin
        cw = cw ^ 16'h0100;
        bad_exp++;
      end
      exp_w[exp_n]   = w0;
      exp_w[exp_n+1] = w1;
      exp_w[exp_n+2] = w2;
      exp_w[exp_n+3] = cw;
      exp_n += 4;
    end

    tx_cnt = 0; rx_cnt = 0; crc_cnt = 0; first_tx = 0; gaps = 0;
    seen_first   = 1'b0;
    ordered_mode = ordered;
    @(negedge lnk_clk);
    lnk_rst_n = 1'b1;
    sys_rst_n = 1'b1;
    mon_en    = 1'b1;

    idx = 0;
    cyc = 0;
    while (idx < exp_n) begin
      if (fillers && (cyc % 5) == 4) begin
        lnk_is_data = 1'b0;
        lnk_word    = 16'hF00D ^ 16'(cyc);
      end else begin
        lnk_is_data = 1'b1;
        lnk_word    = exp_w[idx];
        idx++;
        tx_cnt++;
      end
      cyc++;
      @(negedge lnk_clk);
    end
    lnk_is_data = 1'b0;
    lnk_word    = 16'hBEEF;
    repeat (80) @(negedge lnk_clk);
    @(negedge sys_clk);

    if (ordered) begin
      check(rx_cnt == exp_n, "R1 delivered count", rx_cnt, exp_n);
      check(crc_cnt == bad_exp, "R2 crc pulse count", crc_cnt, bad_exp);
      check(first_tx >= depth, "R3 start depth reached", first_tx, depth);
      check(gaps == 0, "R4 gaps in steady stream", gaps, 0);
      check(overflow == 1'b0, "R6 overflow on balanced stream", overflow, 0);
    end else begin
      check(overflow == 1'b1, "R6 overflow flag", overflow, 1);
      check(rx_cnt < exp_n, "R6 dropped words", rx_cnt, exp_n);
    end
    check(underflow == 1'b1, "R5 underflow after drain", underflow, 1);
    check(out_valid == 1'b0, "R5 out_valid after drain", out_valid, 0);
    check(out_word == '0, "R5 zero word after drain", out_word, 0);
    mon_en = 1'b0;
  endtask

  initial begin
    run_sweep(0, 2, 16, 1'b1, 1'b1);
    run_sweep(1, 4, 16, 1'b1, 1'b1);
    run_sweep(2, 6, 16, 1'b1, 1'b1);
    run_sweep(3, 8, 16, 1'b1, 1'b1);
    run_sweep(4, 10, 16, 1'b1, 1'b1);
    run_sweep(5, 8, 20, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule